// File: doc/BRIEF.md
# DSSS Transmit Byte Spreader

This block turns data bytes from a host into a direct-sequence spread-spectrum chip stream at one chip per microsecond. The host places a byte into a one-entry holding register. While the previous byte is still being spread, the next byte waits there. This lets back-to-back bytes leave the block with no idle chip between them. Each data bit is replaced by a code word taken from a 64-bit pseudo-noise register. The chips are sent as they are for a 1 bit and complemented for a 0 bit.

A three-bit configuration selects how the code is applied. In the first mode the full 64-chip code is applied per bit. In the second, a 32-chip half of the code is applied per bit, and a separate select input picks which half. In the third, double-rate mode, two bits share one 32-chip period: the first bit of the pair picks the code half and the second picks the polarity. An invert flag complements the data before spreading. The outputs are a serial chip line, a chip strobe, a byte-complete pulse, an idle flag and the holding-register state.

Top module: `dsss_tx_spreader`

## Requirements
- R1: While bytes are available, `chip_valid` pulses for one clock once every `CLK_PER_CHIP` clocks. This holds within a byte and across the boundary to a byte that was already waiting.
- R2: With `mode_cfg` = 000, each data bit (taken least significant bit first) becomes 64 chips. The chips are pn[63] down to pn[0], sent unchanged for a 1 bit and complemented for a 0 bit. A byte yields 512 chips.
- R3: With `mode_cfg` = 100 or 101, each bit becomes 32 chips. When `half_sel` is 1 the chips are pn[63] down to pn[32]; when it is 0 they are pn[31] down to pn[0]. A 1 bit sends them true and a 0 bit complements them. A byte yields 256 chips. The mode and `half_sel` are captured when the byte starts.
- R4: With `mode_cfg` = 110, the bits are taken in pairs (bits 1:0 first, then 3:2, and so on). The lower bit of a pair picks the half (1 = pn[63:32], 0 = pn[31:0]). The upper bit picks the polarity (0 = complemented). The 32 chips are sent from the highest index down. A byte yields 128 chips.
- R5: The configuration codes 001, 010, 011 and 111 are never taken as a mode; the last valid code stays in force. After reset the mode is 000.
- R6: After reset the code register holds 0x1E8B6A3DE0E9B222. A one-cycle `pn_wr_en` replaces it with `pn_wr_data`.
- R7: When `tx_invert` is 1 at the start of a byte, the complement of that byte is spread.
- R8: A write (`wr_en` high) is taken only while `hold_full` is 0, and `hold_full` reads 1 on the next cycle. A write while `hold_full` is 1 is dropped and that byte is never sent.
- R9: `byte_done` pulses in the same cycle as the last chip of each byte. If no byte is waiting at that moment, `tx_idle` rises and no further chips appear.
- R10: After reset `tx_idle` is 1 and `hold_full`, `chip_valid` and `byte_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| mode_cfg | input | 3 | Spreading mode {width, double rate, sample} |
| half_sel | input | 1 | Code half for 32-chip normal mode |
| tx_invert | input | 1 | Complement data before spreading |
| pn_wr_en | input | 1 | Load strobe for the code register |
| pn_wr_data | input | 64 | New code word |
| chip_out | output | 1 | Current chip |
| chip_valid | output | 1 | One-clock strobe per chip |
| byte_done | output | 1 | Pulse with the last chip of a byte |
| tx_idle | output | 1 | No byte is being spread |
| hold_full | output | 1 | Holding register occupied |

## Verification
The same chip-by-chip comparison is run for each mode. A byte such as 0x1B covers all four bit pairs in double-rate mode, so it separates a swapped half choice from a swapped polarity. Runs with the lower and upper half, with a loaded code instead of the reset code, and with inversion show whether the code index, the half select and the data path are wired separately and correctly. Two queued bytes followed by an extra write show whether chip timing stays gapless, whether a write to a full register is dropped, and whether the block stops cleanly. Invalid codes entered after a valid one show whether the mode register holds.

// File: rtl/dsss_tx_pkg.sv
// Shared definitions for the DSSS transmit spreader.
// Assumes mode encodings {code width, double rate, sample rate}.
package dsss_tx_pkg;
    typedef enum logic [2:0] {
        SPR_W64    = 3'b000,
        SPR_W32    = 3'b100,
        SPR_W32_OS = 3'b101,
        SPR_DDR    = 3'b110
    } spread_mode_e;

    localparam logic [63:0] PN_DEFAULT = 64'h1E8B6A3DE0E9B222;

    // True for the four encodings accepted as a spreading mode.
    function automatic logic mode_ok(input logic [2:0] m);
        return (m == SPR_W64) || (m == SPR_W32) || (m == SPR_W32_OS) || (m == SPR_DDR);
    endfunction
endpackage

// File: rtl/dsss_chip_tick.sv
// Free-running chip-rate strobe: one clock high every CLK_PER_CHIP clocks.
// Assumes CLK_PER_CHIP >= 2.
module dsss_chip_tick #(
    parameter int CLK_PER_CHIP = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (CLK_PER_CHIP > 1) ? $clog2(CLK_PER_CHIP) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_CHIP - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Divide the system clock down to the chip rate.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/dsss_hold_reg.sv
// One-byte holding register of the double buffer.
// Accepts a write only when empty; the engine pops it when it loads a byte.
module dsss_hold_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    output logic          full,
    output logic [DW-1:0] data
);
    // Capture a byte when empty, release it on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (pop) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

    a_r8_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> (data == $past(data)));
    a_r8_pop_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> full);
endmodule

// File: rtl/dsss_spread_engine.sv
// Spreads one byte at a time into chips, one chip per tick.
// Captures mode, half select and inverted data when a byte starts.
// Loads the waiting byte on the same tick as the last chip so no gap occurs.
module dsss_spread_engine
    import dsss_tx_pkg::*;
#(
    parameter int DW = 8,
    parameter int PN_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            hold_full,
    input  logic [DW-1:0]   hold_data,
    input  logic [2:0]      mode_sel,
    input  logic            half_sel,
    input  logic            invert,
    input  logic [PN_W-1:0] pn,
    output logic            pop,
    output logic            chip_out,
    output logic            chip_valid,
    output logic            byte_done,
    output logic            busy
);
    localparam int IW = $clog2(PN_W);
    localparam int HW = IW - 1;
    localparam int BW = $clog2(DW);

    logic [DW-1:0] shreg_q;
    logic [2:0]    mode_q;
    logic          half_q;
    logic [BW-1:0] per_q;
    logic [IW-1:0] chip_q;

    logic          is64, isddr, end_per, end_byte, bit_a, bit_b, hi, pol, chip_n, load;
    logic [IW-1:0] last_c, idx;
    logic [BW-1:0] last_p;

    // Select the code chip and polarity for the current position.
    always_comb begin
        is64   = (mode_q == SPR_W64);
        isddr  = (mode_q == SPR_DDR);
        last_c = is64 ? IW'(PN_W - 1) : IW'(PN_W / 2 - 1);
        last_p = isddr ? BW'(DW / 2 - 1) : BW'(DW - 1);
        bit_a  = isddr ? shreg_q[{per_q[BW-2:0], 1'b0}] : shreg_q[per_q];
        bit_b  = isddr ? shreg_q[{per_q[BW-2:0], 1'b1}] : bit_a;
        hi     = isddr ? bit_a : half_q;
        pol    = bit_b;
        idx    = is64 ? (IW'(PN_W - 1) - chip_q)
                      : {hi, HW'(PN_W / 2 - 1) - chip_q[HW-1:0]};
        chip_n = pol ? pn[idx] : ~pn[idx];
        end_per  = (chip_q == last_c);
        end_byte = end_per && (per_q == last_p);
        load     = tick && hold_full && (!busy || end_byte);
    end

    assign pop = load;

    // Emit chips, step through the byte and reload from the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            mode_q     <= SPR_W64;
            half_q     <= 1'b0;
            per_q      <= '0;
            chip_q     <= '0;
            busy       <= 1'b0;
            chip_out   <= 1'b0;
            chip_valid <= 1'b0;
            byte_done  <= 1'b0;
        end else begin
            chip_valid <= 1'b0;
            byte_done  <= 1'b0;
            if (tick && busy) begin
                chip_out   <= chip_n;
                chip_valid <= 1'b1;
                if (end_per) begin
                    chip_q <= '0;
                    per_q  <= per_q + 1'b1;
                end else begin
                    chip_q <= chip_q + 1'b1;
                end
                if (end_byte) begin
                    byte_done <= 1'b1;
                    busy      <= 1'b0;
                end
            end
            if (load) begin
                shreg_q <= hold_data ^ {DW{invert}};
                mode_q  <= mode_sel;
                half_q  <= half_sel;
                per_q   <= '0;
                chip_q  <= '0;
                busy    <= 1'b1;
            end
        end
    end

    a_r9_chip_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        chip_valid |-> $past(busy));
    a_r9_done_with_chip: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> chip_valid);
    a_r1_chip_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        chip_valid |=> !chip_valid);
    a_r5_latched_mode_ok: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mode_ok(mode_q));
endmodule

// File: rtl/dsss_tx_spreader.sv
// Top of the DSSS transmit spreader: code register, mode register,
// double buffer and spreading engine. Chips leave at clk / CLK_PER_CHIP.
module dsss_tx_spreader
    import dsss_tx_pkg::*;
#(
    parameter int CLK_PER_CHIP = 50,
    parameter int DW = 8,
    parameter int PN_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic [2:0]      mode_cfg,
    input  logic            half_sel,
    input  logic            tx_invert,
    input  logic            pn_wr_en,
    input  logic [PN_W-1:0] pn_wr_data,
    output logic            chip_out,
    output logic            chip_valid,
    output logic            byte_done,
    output logic            tx_idle,
    output logic            hold_full
);
    logic [PN_W-1:0] pn_q;
    logic [2:0]      mode_q;
    logic [DW-1:0]   hold_data;
    logic            tick, pop, busy;

    // Code register with its reset pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)        pn_q <= PN_W'(PN_DEFAULT);
        else if (pn_wr_en) pn_q <= pn_wr_data;
    end

    // Mode register: takes only valid encodings.
    always_ff @(posedge clk) begin
        if (!rst_n)                mode_q <= SPR_W64;
        else if (mode_ok(mode_cfg)) mode_q <= mode_cfg;
    end

    dsss_chip_tick #(.CLK_PER_CHIP(CLK_PER_CHIP)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    dsss_hold_reg #(.DW(DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pop(pop), .full(hold_full), .data(hold_data)
    );

    dsss_spread_engine #(.DW(DW), .PN_W(PN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold_full(hold_full),
        .hold_data(hold_data), .mode_sel(mode_q), .half_sel(half_sel),
        .invert(tx_invert), .pn(pn_q), .pop(pop), .chip_out(chip_out),
        .chip_valid(chip_valid), .byte_done(byte_done), .busy(busy)
    );

    assign tx_idle = !busy;

    a_r5_bad_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok(mode_cfg) |=> (mode_q == $past(mode_q)));
    a_r6_pn_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !pn_wr_en |=> (pn_q == $past(pn_q)));
    a_r8_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hold_full) |=> hold_full);
endmodule

// File: tb/sim_dsss_tx_spreader.sv
`timescale 1ns/1ps
module sim_dsss_tx_spreader;
    localparam int CPC = 4;
    localparam logic [63:0] PN_RST = 64'h1E8B6A3DE0E9B222;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, half_sel = 1'b0, tx_invert = 1'b0, pn_wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] mode_cfg = 3'b000;
    logic [63:0] pn_wr_data = '0;
    logic chip_out, chip_valid, byte_done, tx_idle, hold_full;

    int checks = 0, fails = 0, ncap = 0, ndone = 0, cyc = 0;
    logic cap [0:1199];
    int   tcap [0:1199];
    int   done_at [0:15];
    logic finished = 1'b0;

    always #10 clk = ~clk;

    dsss_tx_spreader #(.CLK_PER_CHIP(CPC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode_cfg(mode_cfg), .half_sel(half_sel), .tx_invert(tx_invert),
        .pn_wr_en(pn_wr_en), .pn_wr_data(pn_wr_data), .chip_out(chip_out),
        .chip_valid(chip_valid), .byte_done(byte_done), .tx_idle(tx_idle),
        .hold_full(hold_full)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: capture chips and byte ends away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (chip_valid && ncap < 1200) begin
                cap[ncap] = chip_out;
                tcap[ncap] = cyc;
                ncap = ncap + 1;
            end
            if (byte_done && ndone < 16) begin
                done_at[ndone] = ncap;
                ndone = ndone + 1;
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int chips_per_byte(input logic [2:0] m);
        if (m == 3'b000) return 512;
        if (m == 3'b110) return 128;
        return 256;
    endfunction

    // Expected chip k of a byte, from the requirement text.
    function automatic logic exp_chip(input logic [63:0] pn, input logic [2:0] m,
                                      input logic half, input logic [7:0] d, input int k);
        int c, i;
        logic b, a;
        if (m == 3'b000) begin
            b = d[k / 64]; c = k % 64; i = 63 - c;
        end else if (m == 3'b110) begin
            a = d[2 * (k / 32)]; b = d[2 * (k / 32) + 1]; c = k % 32;
            i = (a ? 32 : 0) + 31 - c;
        end else begin
            b = d[k / 32]; c = k % 32; i = (half ? 32 : 0) + 31 - c;
        end
        return b ? pn[i] : ~pn[i];
    endfunction

    task automatic cmp_stream(input string req, input int base, input logic [63:0] pn,
                              input logic [2:0] m, input logic half, input logic [7:0] d);
        int n = chips_per_byte(m);
        int bad = 0, first = -1;
        for (int k = 0; k < n; k++) begin
            if (base + k >= ncap || cap[base + k] !== exp_chip(pn, m, half, d, k)) begin
                bad++;
                if (first < 0) first = k;
            end
        end
        check(bad == 0, req, first, -1);
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done(input int n);
        int t = 0;
        while (ndone < n && t < 6000) begin
            @(negedge clk); t++;
        end
        repeat (3 * CPC) @(negedge clk);
    endtask

    task automatic clear_cap();
        ncap = 0; ndone = 0;
    endtask

    task automatic t_reset();
        check(tx_idle === 1'b1, "R10 idle", int'(tx_idle), 1);
        check(hold_full === 1'b0, "R10 hold", int'(hold_full), 0);
        check(chip_valid === 1'b0 && byte_done === 1'b0, "R10 strobes",
              int'({chip_valid, byte_done}), 0);
    endtask

    task automatic one_byte(input string req, input logic [2:0] m, input logic half,
                            input logic inv, input logic [7:0] d, input logic [63:0] pn);
        clear_cap();
        mode_cfg = m; half_sel = half; tx_invert = inv;
        wr_byte(d);
        wait_done(1);
        cmp_stream(req, 0, pn, m, half, inv ? ~d : d);
        check(ncap == chips_per_byte(m), {req, " count"}, ncap, chips_per_byte(m));
        check(ndone == 1 && done_at[0] == ncap, "R9 done with last chip", done_at[0], ncap);
        check(tx_idle === 1'b1, "R9 idle after byte", int'(tx_idle), 1);
    endtask

    task automatic t_mode64();  one_byte("R2 R6 64-chip", 3'b000, 1'b0, 1'b0, 8'hA5, PN_RST); endtask
    task automatic t_mode32();
        one_byte("R3 lower half", 3'b100, 1'b0, 1'b0, 8'h6C, PN_RST);
        one_byte("R3 upper half", 3'b101, 1'b1, 1'b0, 8'h6C, PN_RST);
    endtask
    task automatic t_ddr();     one_byte("R4 double rate", 3'b110, 1'b0, 1'b0, 8'h1B, PN_RST); endtask
    task automatic t_invert();  one_byte("R7 invert", 3'b100, 1'b1, 1'b1, 8'h3C, PN_RST); endtask

    task automatic t_pn_load();
        logic [63:0] p = 64'h0123456789ABCDEF;
        @(negedge clk); pn_wr_en = 1'b1; pn_wr_data = p;
        @(negedge clk); pn_wr_en = 1'b0;
        one_byte("R6 loaded code", 3'b000, 1'b0, 1'b0, 8'h96, p);
        @(negedge clk); pn_wr_en = 1'b1; pn_wr_data = PN_RST;
        @(negedge clk); pn_wr_en = 1'b0;
    endtask

    task automatic t_bad_mode();
        clear_cap();
        mode_cfg = 3'b100; half_sel = 1'b0; tx_invert = 1'b0;
        repeat (2) @(negedge clk);
        mode_cfg = 3'b111;
        repeat (2) @(negedge clk);
        mode_cfg = 3'b001;
        wr_byte(8'h5A);
        wait_done(1);
        cmp_stream("R5 invalid code ignored", 0, PN_RST, 3'b100, 1'b0, 8'h5A);
        check(ncap == 256, "R5 count", ncap, 256);
        mode_cfg = 3'b000;
    endtask

    task automatic t_queue_drop();
        int t = 0;
        logic gap_ok = 1'b1;
        clear_cap();
        mode_cfg = 3'b110; half_sel = 1'b0; tx_invert = 1'b0;
        wr_byte(8'hC3);
        check(hold_full === 1'b1, "R8 write fills", int'(hold_full), 1);
        while (hold_full && t < 100) begin @(negedge clk); t++; end
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h4E;
        @(negedge clk);
        wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        check(hold_full === 1'b1, "R8 second byte waiting", int'(hold_full), 1);
        wait_done(2);
        repeat (300 * CPC) @(negedge clk);
        check(ncap == 256 && ndone == 2, "R8 dropped write", ncap, 256);
        cmp_stream("R4 first queued", 0, PN_RST, 3'b110, 1'b0, 8'hC3);
        cmp_stream("R4 second queued", 128, PN_RST, 3'b110, 1'b0, 8'h4E);
        for (int k = 1; k < ncap; k++)
            if (tcap[k] - tcap[k - 1] != CPC) gap_ok = 1'b0;
        check(gap_ok, "R1 gapless chips", 0, CPC);
        check(tx_idle === 1'b1 && hold_full === 1'b0, "R9 idle after queue",
              int'({tx_idle, hold_full}), 2);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode64();
        t_mode32();
        t_ddr();
        t_invert();
        t_pn_load();
        t_bad_mode();
        t_queue_drop();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule